// File: doc/BRIEF.md
# PLL Control and Lock-Change Interrupt Registers

This block holds the software-visible controls of a clock-generator PLL: an enable for the loop, a select that moves the base clock onto the divided VCO output, an interrupt enable, an automatic-interrupt mode bit, a 4-bit range multiplier and a 4-bit VCO range field. The fields drive the analog loop and the clock multiplexer directly. A small register bus reads and writes them.

The block takes an asynchronous lock indication from the loop and synchronizes it. In automatic mode it raises an interrupt flag on every lock transition, both into lock and out of it. Software reads the status register, sees the flag and the live lock bit, and from those learns which transition occurred. The read also clears the flag. Two guards protect the loop. The multiplier and range fields are frozen while the loop is enabled, and a zero range field keeps the loop off and the base clock away from the VCO.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset the loop enable, clock select, interrupt enable, automatic mode, flag and range field are 0, and the multiplier is 4'h6.
- R2: With automatic mode set, each rising and each falling change of the lock input sets the flag. The flag is bit 4 of the control register at address 0. It becomes visible three clock edges after the input changes.
- R3: The flag is set on a lock change whatever the interrupt enable holds. The irq output is 1 exactly when the flag and the interrupt enable (control bit 2) are both 1.
- R4: With automatic mode clear (control bit 3 = 0), the flag reads 0, irq stays 0 and lock changes set nothing.
- R5: A write to the multiplier (address 1, bits 3:0) is ignored while the loop enable (control bit 0) is 1.
- R6: A write to the range field (address 2, bits 3:0) is ignored while the loop enable is 1.
- R7: While the range field is zero, writes cannot set the clock select (control bit 1) or the loop enable. Making the range field zero clears both.
- R8: The clock select can be set while the synchronized lock is 0, provided the range field is nonzero.
- R9: A read of address 0 that returns the flag as 1 clears the flag on the next edge. A lock change detected in that same cycle keeps the flag set.
- R10: Control bit 5 is read-only and returns the synchronized lock. Writes to bits 4 and 5 change nothing. Address 3 and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; a read of address 0 may clear the flag |
| addr | input | 2 | Register address: 0 control/status, 1 multiplier, 2 range |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| lock_async | input | 1 | Lock indication from the analog loop, asynchronous |
| pll_on | output | 1 | Loop enable to the analog PLL |
| clk_sel | output | 1 | Base clock select to the clock multiplexer |
| mult | output | 4 | Range multiplier to the analog PLL |
| vrange | output | 4 | VCO range field to the analog PLL |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the status read that lands in the same cycle as a detected lock change. The lock input passes through two synchronizer stages before the change is seen, so the read has to arrive exactly two edges after the input toggles. The bench sets the flag with one toggle, enables irq, toggles the lock again and places the read strobe on the second falling edge after that toggle. It then checks that irq is still asserted. A long random phase also changes the lock input while reads arrive. A per-cycle reference model checks each of these collisions.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
    localparam int FIELD_W = 4;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MULT = 2'd1;
    localparam logic [ADDR_W-1:0] A_VRNG = 2'd2;

    localparam int B_ON   = 0;
    localparam int B_SEL  = 1;
    localparam int B_IE   = 2;
    localparam int B_AUTO = 3;
    localparam int B_FLAG = 4;
    localparam int B_LOCK = 5;

    localparam logic [FIELD_W-1:0] MULT_RST = 4'h6;

    typedef struct packed {
        logic               pll_on;
        logic               clk_sel;
        logic               irq_en;
        logic               auto_md;
        logic [FIELD_W-1:0] mult;
        logic [FIELD_W-1:0] vrange;
    } ctrl_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_async,
    output logic lock_s,
    output logic lock_chg
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    assign sh_d[0] = lock_async;
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign sh_d[g] = sh_q[g-1];
    end

    assign lock_s   = sh_q[STAGES-1];
    assign lock_chg = lock_s ^ prev_q;

    always_comb prev_d = lock_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/pll_irq_flag.sv
module pll_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_nxt,
    input  logic lock_chg,
    input  logic rd_clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        if (!auto_nxt)     flag_d = 1'b0;
        else if (lock_chg) flag_d = 1'b1;
        else if (rd_clr)   flag_d = 1'b0;
        else               flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
    import pll_ctrl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               lock_async,
    output logic               pll_on,
    output logic               clk_sel,
    output logic [FIELD_W-1:0] mult,
    output logic [FIELD_W-1:0] vrange,
    output logic               irq
);
    ctrl_t q, d;
    logic  lock_s, lock_chg, flag, rd_clr;
    logic  unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:B_FLAG];

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lock_async(lock_async),
        .lock_s(lock_s), .lock_chg(lock_chg)
    );

    assign rd_clr = rd_en && (addr == A_CTRL) && flag;

    pll_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .auto_nxt(d.auto_md),
        .lock_chg(lock_chg), .rd_clr(rd_clr), .flag(flag)
    );

    always_comb begin
        d = q;
        if (wr_en && addr == A_CTRL) begin
            d.pll_on  = wdata[B_ON];
            d.irq_en  = wdata[B_IE];
            d.auto_md = wdata[B_AUTO];
            d.clk_sel = wdata[B_SEL] && (q.vrange != '0);
        end
        if (wr_en && addr == A_MULT && !q.pll_on)
            d.mult = wdata[FIELD_W-1:0];
        if (wr_en && addr == A_VRNG && !q.pll_on)
            d.vrange = wdata[FIELD_W-1:0];
        if (d.vrange == '0) begin
            d.pll_on  = 1'b0;
            d.clk_sel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.mult   <= MULT_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_ON]   = q.pll_on;
                rdata[B_SEL]  = q.clk_sel;
                rdata[B_IE]   = q.irq_en;
                rdata[B_AUTO] = q.auto_md;
                rdata[B_FLAG] = flag;
                rdata[B_LOCK] = lock_s;
            end
            A_MULT:  rdata[FIELD_W-1:0] = q.mult;
            A_VRNG:  rdata[FIELD_W-1:0] = q.vrange;
            default: rdata = '0;
        endcase
    end

    assign pll_on  = q.pll_on;
    assign clk_sel = q.clk_sel;
    assign mult    = q.mult;
    assign vrange  = q.vrange;
    assign irq     = flag && q.irq_en;
endmodule

// File: rtl/pll_ctrl_chk.sv
module pll_ctrl_chk
    import pll_ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               pll_on,
    input logic               clk_sel,
    input logic [FIELD_W-1:0] mult,
    input logic [FIELD_W-1:0] vrange,
    input logic               irq,
    input logic               flag,
    input logic               auto_md,
    input logic               lock_chg
);
    // R2: a detected change in automatic mode leaves the flag set next cycle
    assert_chg_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_chg && auto_md && !(wr_en && addr == A_CTRL)) |=> flag);

    // R3: an interrupt request needs the automatic mode that produces the flag
    assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && auto_md));

    // R4: no flag outside automatic mode
    assert_flag_off_manual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_md |-> !flag);

    // R5: multiplier frozen while running
    assert_mult_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_on |=> $stable(mult));

    // R6: range field frozen while running
    assert_vrange_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_on |=> $stable(vrange));

    // R7: zero range keeps loop off and clock on the reference
    assert_zero_range_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vrange == '0) |-> (!clk_sel && !pll_on));

    // R9: status read without a concurrent change clears the flag
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CTRL && flag && !lock_chg) |=> !flag);
endmodule

bind pll_ctrl_regs pll_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .pll_on(pll_on), .clk_sel(clk_sel), .mult(mult), .vrange(vrange),
    .irq(irq), .flag(flag), .auto_md(q.auto_md), .lock_chg(lock_chg)
);

// File: tb/tb_pll_ctrl_regs.sv
`timescale 1ns/1ps
module tb_pll_ctrl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       lock_async = 1'b0;
    logic       pll_on, clk_sel, irq;
    logic [3:0] mult, vrange;

    int checks = 0, fails = 0;

    // reference model state
    int m_on, m_sel, m_ie, m_auto, m_flag, m_mult, m_vr;
    int lk[$];   // lock samples, oldest first; size 3 = {prev, s2, s1}

    always #4 clk = ~clk;

    pll_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lock_async(lock_async),
        .pll_on(pll_on), .clk_sel(clk_sel), .mult(mult), .vrange(vrange), .irq(irq)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_rdata(int a);
        case (a)
            0: return m_on | (m_sel << 1) | (m_ie << 2) | (m_auto << 3)
                      | (m_flag << 4) | (lk[1] << 5);
            1: return m_mult;
            2: return m_vr;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on = 0; m_sel = 0; m_ie = 0; m_auto = 0; m_flag = 0;
            m_mult = 6; m_vr = 0;
            lk = '{0, 0, 0};
        end else begin
            bit change, rclr;
            int nauto, nvr;
            change = (lk[1] != lk[0]);
            rclr   = rd_en && addr == 0 && m_flag == 1;
            nauto  = m_auto;
            nvr    = m_vr;
            if (wr_en && addr == 0) begin
                m_on = wdata[0]; m_ie = wdata[2]; nauto = wdata[3];
                m_sel = (wdata[1] && m_vr != 0) ? 1 : 0;
            end
            if (wr_en && addr == 1 && m_on == 0 && !(wr_en && addr == 0)) m_mult = wdata[3:0];
            if (wr_en && addr == 2 && m_on == 0) nvr = wdata[3:0];
            m_vr = nvr;
            if (m_vr == 0) begin m_on = 0; m_sel = 0; end
            m_auto = nauto;
            if (m_auto == 0)  m_flag = 0;
            else if (change)  m_flag = 1;
            else if (rclr)    m_flag = 0;
            void'(lk.pop_front());
            lk.push_back(int'(lock_async));
        end
    end

    // per-cycle comparison, away from both edges
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R5 mult",     mult,    m_mult);
            chk("R6 vrange",   vrange,  m_vr);
            chk("R7 pll_on",   pll_on,  m_on);
            chk("R8 clk_sel",  clk_sel, m_sel);
            chk("R3 irq",      irq,     m_flag & m_ie);
            chk("R10 rdata",   rdata,   m_rdata(addr));
        end
    end

    task automatic wr(int a, int v);
        @(negedge clk); wr_en = 1; rd_en = 0; addr = 2'(a); wdata = 8'(v);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk); wr_en = 0; rd_en = 1; addr = 2'(a);
        #1 v = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                #1_000_000;
                fails++; checks++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        join_none
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, v); chk("R1 ctrl reset", v, 0);
        rd(1, v); chk("R1 mult reset", v, 6);
        rd(2, v); chk("R1 vrange reset", v, 0);
        rd(3, v); chk("R10 addr3 reads 0", v, 0);
        // R7 zero range blocks select and enable
        wr(0, 8'h03); rd(0, v); chk("R7 blocked with zero range", v & 3, 0);
        wr(1, 9); wr(2, 5);
        rd(1, v); chk("R5 mult write while off", v, 9);
        rd(2, v); chk("R6 vrange write while off", v, 5);
        // R8 select while unlocked
        wr(0, 8'h03); rd(0, v); chk("R8 select with lock 0", v & 8'h23, 3);
        // R5 R6 frozen while on
        wr(1, 3); wr(2, 2);
        rd(1, v); chk("R5 mult frozen", v, 9);
        rd(2, v); chk("R6 vrange frozen", v, 5);
        // R4 manual mode: toggles do nothing
        wr(0, 8'h07);
        @(negedge clk) lock_async = 1; idle(5);
        @(negedge clk) lock_async = 0; idle(5);
        rd(0, v); chk("R4 flag stays 0", (v >> 4) & 1, 0);
        chk("R4 irq stays 0", irq, 0);
        // R2 R3 automatic mode, enable off
        wr(0, 8'h0B);
        @(negedge clk) lock_async = 1; idle(4);
        chk("R3 irq off with enable 0", irq, 0);
        wr(0, 8'h0F);
        #1 chk("R3 irq on with enable", irq, 1);
        // R9 read clears
        rd(0, v); chk("R2 rising flag", (v >> 4) & 3, 3);
        #1 chk("R9 cleared after read", irq, 0);
        // R2 falling
        @(negedge clk) lock_async = 0; idle(4);
        #1 chk("R2 falling sets flag", irq, 1);
        // R9 collision: read in detection cycle
        @(negedge clk) lock_async = 1;
        @(negedge clk);
        @(negedge clk) begin rd_en = 1; addr = 0; end
        @(negedge clk) rd_en = 0;
        #1 chk("R9 change beats clear", irq, 1);
        // R10 lock bit read-only
        wr(0, 8'h3F); rd(0, v);
        chk("R10 lock bit live", (v >> 5) & 1, 1);
        @(negedge clk) lock_async = 0; idle(3);
        wr(0, 8'h2E); rd(0, v);
        chk("R10 lock bit not writable", (v >> 5) & 1, 0);
        // R7 zero range clears select
        wr(0, 8'h02); wr(2, 0);
        rd(0, v); chk("R7 zero range clears select", v & 3, 0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en = ($urandom % 3) == 0;
            rd_en = ($urandom % 2) == 0;
            addr  = 2'($urandom);
            wdata = 8'($urandom);
            if (($urandom % 7) == 0) lock_async = ~lock_async;
        end
        @(negedge clk) begin wr_en = 0; rd_en = 0; end
        idle(4);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule